// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

A passive observer for a four-bank synchronous DRAM command bus. On every rising clock edge it reads the chip-select, row-strobe, column-strobe and write-enable levels together with the bank address and the auto-precharge/all-banks address bit (A10). From these it decodes the command and keeps an open/closed record for every bank. It measures the cycle distance between related commands against minimum gaps set by parameters, and reports the first broken rule of each cycle as a one-cycle pulse with a cause code.

The monitor drives nothing on the memory bus. It sits beside a memory controller in simulation or in silicon, and an integrator reads its sticky flag, its last cause code and its per-bank open vector. Refresh means auto refresh with clock enable held high. Clock-enable power states and data-path contents are not modelled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n high the cycle is a deselect: no bank changes state and no error is raised for it. With cs_n low, {ras_n,cas_n,we_n} decodes as 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode write and 110 burst stop.
- R2: After reset every bit of bank_open is 0. A legal activate sets bank_open[ba] in the cycle after the command.
- R3: A precharge with a10 high closes every bank whatever ba holds. With a10 low it closes only bank ba.
- R4: A mode write while any bank is open gives code 2. A refresh while any bank is open gives code 3.
- R5: Any command except no-op or deselect issued fewer than TMRD cycles after a mode write gives code 1.
- R6: A read or write with a10 high starts an auto-precharge burst of BL cycles. A read, write or precharge to that bank during the burst gives code 6. The bank closes after the last burst cycle, and a later activate of it needs TRP cycles counted from that last cycle (code 9).
- R7: Minimum gaps: activate to read/write of the same bank TRCD (code 7), activate to precharge TRAS (code 8), precharge to activate TRP (code 9), and activate to activate on any bank TRRD (code 10).
- R8: A precharge of a bank fewer than BL-1+TWR cycles after a write to it gives code 11.
- R9: Read and write commands to open banks may follow one another on consecutive cycles with no error.
- R10: A read or write to a closed bank gives code 5. An activate of an open bank gives code 4 and does not change its state.
- R11: If REF_INT cycles pass after reset or after the last refresh with no refresh, code 12 is raised once, in that cycle.
- R12: err_pulse is high for one cycle, in the cycle after the offending edge. err_code holds the cause of the latest error and err_flag stays high until reset. When several rules break on one edge, the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 4 | Cause of the most recent error |
| err_flag | output | 1 | Sticky error flag |
| bank_open | output | 4 | Open state of each bank |

## Verification
The main sequence interleaves activates, column commands, precharges, mode writes and refreshes so that every gap rule is hit once just inside its limit and once just outside. Cases on the limit show whether the comparison is off by one. An activate to an open bank that also breaks the activate-to-activate gap shows whether the priority is right. A single precharge and an all-banks precharge with a mismatched ba tell the two close paths apart. A long run of deselects that carry row-strobe levels separates deselect handling from the refresh-interval alarm, and an auto-precharge read followed by an early activate places the burst end to the exact cycle.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  // Numeric values are the reported cause codes; lower value wins.
  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_MRD       = 4'd1,
    E_MRS_OPEN  = 4'd2,
    E_REF_OPEN  = 4'd3,
    E_ACT_OPEN  = 4'd4,
    E_RW_CLOSED = 4'd5,
    E_AP_BUSY   = 4'd6,
    E_TRCD      = 4'd7,
    E_TRAS      = 4'd8,
    E_TRP       = 4'd9,
    E_TRRD      = 4'd10,
    E_TWR       = 4'd11,
    E_REF_LATE  = 4'd12
  } err_e;

  typedef struct packed {
    logic act_open;
    logic rw_closed;
    logic ap_busy;
    logic trcd;
    logic tras;
    logic trp;
    logic twr;
  } bank_viol_t;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_BST;
      endcase
    end
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  output cmd_e           cmd,
  output logic [NB-1:0]  bank_sel
);
  always_comb begin
    cmd          = decode_cmd(cs_n, ras_n, cas_n, we_n);
    bank_sel     = '0;
    bank_sel[ba] = 1'b1;
  end
endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int TRCD   = 3,
  parameter int TRAS   = 6,
  parameter int TRP    = 3,
  parameter int WR_GAP = 5,
  parameter int BL     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       sel,
  input  logic       a10,
  output logic       is_open,
  output logic       ap_busy,
  output bank_viol_t viol
);
  localparam int CAP    = max2(max2(TRCD, TRAS), max2(TRP, WR_GAP));
  localparam int CW     = $clog2(CAP + 1);
  localparam int AW     = $clog2(BL + 1);
  localparam bit AP_NOW = (BL == 1);

  // Cycles elapsed since an event, held at CAP once every limit is met.
  function automatic logic [CW-1:0] since_next(input logic [CW-1:0] c);
    return (c >= CW'(CAP)) ? CW'(CAP) : c + CW'(1);
  endfunction

  logic          open_q;
  logic [CW-1:0] act_cnt, pre_cnt, wr_cnt;
  logic [AW-1:0] ap_rem;
  logic          hit_rw, hit_act, hit_pre;

  always_comb begin
    ap_busy = (ap_rem != '0);
    hit_rw  = sel && (cmd == CMD_RD || cmd == CMD_WR);
    hit_act = sel && (cmd == CMD_ACT);
    hit_pre = (cmd == CMD_PRE) && (sel || a10);

    viol.ap_busy   = ap_busy && (hit_rw || hit_pre);
    viol.rw_closed = hit_rw && !open_q;
    viol.trcd      = hit_rw && open_q && !ap_busy && (act_cnt < CW'(TRCD));
    viol.act_open  = hit_act && open_q;
    viol.trp       = hit_act && !open_q && (pre_cnt < CW'(TRP));
    viol.tras      = hit_pre && open_q && !ap_busy && (act_cnt < CW'(TRAS));
    viol.twr       = hit_pre && open_q && !ap_busy && (wr_cnt < CW'(WR_GAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      act_cnt <= CW'(CAP);
      pre_cnt <= CW'(CAP);
      wr_cnt  <= CW'(CAP);
      ap_rem  <= '0;
    end else begin
      act_cnt <= since_next(act_cnt);
      pre_cnt <= since_next(pre_cnt);
      wr_cnt  <= since_next(wr_cnt);
      if (ap_busy) begin
        ap_rem <= ap_rem - AW'(1);
        if (ap_rem == AW'(1)) begin
          open_q  <= 1'b0;
          pre_cnt <= CW'(1);
        end
      end else if (open_q) begin
        if (hit_rw) begin
          if (cmd == CMD_WR) wr_cnt <= CW'(1);
          if (a10) begin
            if (AP_NOW) begin
              open_q  <= 1'b0;
              pre_cnt <= CW'(1);
            end else begin
              ap_rem <= AW'(BL - 1);
            end
          end
        end else if (hit_pre) begin
          open_q  <= 1'b0;
          pre_cnt <= CW'(1);
        end
      end else if (hit_act) begin
        open_q  <= 1'b1;
        act_cnt <= CW'(1);
      end
    end
  end

  assign is_open = open_q;
endmodule

// File: rtl/sdram_mon_global.sv
module sdram_mon_global
  import sdram_mon_pkg::*;
#(
  parameter int TRRD    = 2,
  parameter int TMRD    = 2,
  parameter int REF_INT = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic any_open,
  output logic v_trrd,
  output logic v_mrd,
  output logic v_mrs_open,
  output logic v_ref_open,
  output logic v_late
);
  localparam int CAP = max2(TRRD, TMRD);
  localparam int CW  = $clog2(CAP + 1);
  localparam int RW  = $clog2(REF_INT + 2);

  function automatic logic [CW-1:0] since_next(input logic [CW-1:0] c);
    return (c >= CW'(CAP)) ? CW'(CAP) : c + CW'(1);
  endfunction

  function automatic logic [RW-1:0] ref_next(input logic [RW-1:0] c,
                                             input logic refreshed);
    if (refreshed) return RW'(1);
    return (c > RW'(REF_INT)) ? c : c + RW'(1);
  endfunction

  logic [CW-1:0] act_g, mrs_g;
  logic [RW-1:0] ref_cnt;
  logic          is_ref;

  always_comb begin
    is_ref     = (cmd == CMD_REF);
    v_trrd     = (cmd == CMD_ACT) && (act_g < CW'(TRRD));
    v_mrd      = (cmd != CMD_NOP) && (cmd != CMD_DESEL) && (mrs_g < CW'(TMRD));
    v_mrs_open = (cmd == CMD_MRS) && any_open;
    v_ref_open = is_ref && any_open;
    v_late     = (ref_cnt == RW'(REF_INT)) && !is_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_g   <= CW'(CAP);
      mrs_g   <= CW'(CAP);
      ref_cnt <= '0;
    end else begin
      act_g   <= (cmd == CMD_ACT) ? CW'(1) : since_next(act_g);
      mrs_g   <= (cmd == CMD_MRS) ? CW'(1) : since_next(mrs_g);
      ref_cnt <= ref_next(ref_cnt, is_ref);
    end
  end
endmodule

// File: rtl/sdram_mon_report.sv
module sdram_mon_report
  import sdram_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bank_viol_t vb,
  input  logic       v_trrd,
  input  logic       v_mrd,
  input  logic       v_mrs_open,
  input  logic       v_ref_open,
  input  logic       v_late,
  output logic       err_pulse,
  output logic [3:0] err_code,
  output logic       err_flag
);
  err_e code_now, code_q;

  always_comb begin
    if (v_mrd)             code_now = E_MRD;
    else if (v_mrs_open)   code_now = E_MRS_OPEN;
    else if (v_ref_open)   code_now = E_REF_OPEN;
    else if (vb.act_open)  code_now = E_ACT_OPEN;
    else if (vb.rw_closed) code_now = E_RW_CLOSED;
    else if (vb.ap_busy)   code_now = E_AP_BUSY;
    else if (vb.trcd)      code_now = E_TRCD;
    else if (vb.tras)      code_now = E_TRAS;
    else if (vb.trp)       code_now = E_TRP;
    else if (v_trrd)       code_now = E_TRRD;
    else if (vb.twr)       code_now = E_TWR;
    else if (v_late)       code_now = E_REF_LATE;
    else                   code_now = E_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_flag  <= 1'b0;
      code_q    <= E_NONE;
    end else begin
      err_pulse <= (code_now != E_NONE);
      if (code_now != E_NONE) begin
        code_q   <= code_now;
        err_flag <= 1'b1;
      end
    end
  end

  assign err_code = code_q;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NB      = 4,
  parameter int TRCD    = 3,
  parameter int TRAS    = 6,
  parameter int TRP     = 3,
  parameter int TRRD    = 2,
  parameter int TWR     = 2,
  parameter int TMRD    = 2,
  parameter int BL      = 4,
  parameter int REF_INT = 1040
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [$clog2(NB)-1:0]  ba,
  input  logic                   a10,
  output logic                   err_pulse,
  output logic [3:0]             err_code,
  output logic                   err_flag,
  output logic [NB-1:0]          bank_open
);
  localparam int BAW    = $clog2(NB);
  localparam int WR_GAP = BL - 1 + TWR;

  cmd_e         cmd;
  logic [NB-1:0] bank_sel;
  logic [NB-1:0] ap_busy_vec;
  bank_viol_t   viol_b [NB];
  bank_viol_t   viol_any;
  logic         v_trrd, v_mrd, v_mrs_open, v_ref_open, late_now;

  sdram_mon_decode #(.NB(NB), .BAW(BAW)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .cmd(cmd), .bank_sel(bank_sel)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_mon_bank #(
      .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .WR_GAP(WR_GAP), .BL(BL)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(bank_sel[g]), .a10(a10),
      .is_open(bank_open[g]), .ap_busy(ap_busy_vec[g]), .viol(viol_b[g])
    );
  end

  always_comb begin
    viol_any = '0;
    for (int i = 0; i < NB; i++) viol_any = bank_viol_t'(viol_any | viol_b[i]);
  end

  sdram_mon_global #(.TRRD(TRRD), .TMRD(TMRD), .REF_INT(REF_INT)) u_glob (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .any_open(|bank_open),
    .v_trrd(v_trrd), .v_mrd(v_mrd), .v_mrs_open(v_mrs_open),
    .v_ref_open(v_ref_open), .v_late(late_now)
  );

  sdram_mon_report u_rep (
    .clk(clk), .rst_n(rst_n), .vb(viol_any),
    .v_trrd(v_trrd), .v_mrd(v_mrd), .v_mrs_open(v_mrs_open),
    .v_ref_open(v_ref_open), .v_late(late_now),
    .err_pulse(err_pulse), .err_code(err_code), .err_flag(err_flag)
  );
endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  ras_n,
  input logic                  cas_n,
  input logic                  we_n,
  input logic [$clog2(NB)-1:0] ba,
  input logic                  a10,
  input logic [NB-1:0]         bank_open,
  input logic [NB-1:0]         ap_busy_vec,
  input logic                  late_now,
  input logic                  err_pulse,
  input logic [3:0]            err_code,
  input logic                  err_flag
);
  logic is_act, is_pre, is_mrs, is_col;
  always_comb begin
    is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    is_col = !cs_n &&  ras_n && !cas_n;
  end

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r12_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flag && err_code != 4'd0));

  a_r1_deselect_no_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ap_busy_vec == '0) |=> $stable(bank_open));

  a_r1_deselect_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !late_now) |=> !err_pulse);

  a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !bank_open[ba]) |=> bank_open[$past(ba)]);

  a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10 && ap_busy_vec == '0) |=> (bank_open == '0));

  a_r4_mode_write_open: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && |bank_open) |=> err_pulse);

  a_r10_column_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !bank_open[ba]) |=> err_pulse);
endmodule

bind sdram_cmd_monitor sdram_mon_checker #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .a10(a10), .bank_open(bank_open),
  .ap_busy_vec(ap_busy_vec), .late_now(late_now), .err_pulse(err_pulse),
  .err_code(err_code), .err_flag(err_flag)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD  = 4'b0101,
                         WR  = 4'b0100, PRE = 4'b0010, REF = 4'b0001,
                         MRS = 4'b0000, DES = 4'b1111, DSR = 4'b1000;
  localparam int N_ROWS = 32;
  localparam int LATE   = 60;

  // Row fields: [18:15] req, [14:11] pins, [10:9] ba, [8] a10, [7:4] code, [3:0] open
  localparam logic [18:0] TBL [N_ROWS] = '{
    {4'd1,  NOP, 2'd0, 1'b0, 4'd0,  4'b0000}, // c0  R1 no-op
    {4'd2,  ACT, 2'd0, 1'b0, 4'd0,  4'b0001}, // c1  R2 open bank 0
    {4'd7,  ACT, 2'd1, 1'b0, 4'd10, 4'b0011}, // c2  R7 act-act gap 1
    {4'd7,  RD,  2'd0, 1'b0, 4'd7,  4'b0011}, // c3  R7 read 2 after act
    {4'd9,  RD,  2'd0, 1'b0, 4'd0,  4'b0011}, // c4  R9 read on limit
    {4'd9,  WR,  2'd0, 1'b0, 4'd0,  4'b0011}, // c5  R9 back-to-back
    {4'd9,  WR,  2'd1, 1'b0, 4'd0,  4'b0011}, // c6  R9
    {4'd8,  PRE, 2'd0, 1'b0, 4'd11, 4'b0010}, // c7  R8 write recovery
    {4'd7,  ACT, 2'd0, 1'b0, 4'd9,  4'b0011}, // c8  R7 precharge-act gap 1
    {4'd12, ACT, 2'd0, 1'b0, 4'd4,  4'b0011}, // c9  R12 code 4 beats 10
    {4'd10, RD,  2'd2, 1'b0, 4'd5,  4'b0011}, // c10 R10 closed bank
    {4'd1,  NOP, 2'd0, 1'b0, 4'd0,  4'b0011}, // c11 R1
    {4'd4,  MRS, 2'd0, 1'b0, 4'd2,  4'b0011}, // c12 R4 mode write, banks open
    {4'd5,  NOP, 2'd0, 1'b0, 4'd0,  4'b0011}, // c13 R5 no-op allowed
    {4'd3,  PRE, 2'd1, 1'b1, 4'd0,  4'b0000}, // c14 R3 all banks, gap 2 ok
    {4'd4,  MRS, 2'd0, 1'b0, 4'd0,  4'b0000}, // c15 R4 legal mode write
    {4'd5,  ACT, 2'd3, 1'b0, 4'd1,  4'b1000}, // c16 R5 too soon
    {4'd5,  NOP, 2'd0, 1'b0, 4'd0,  4'b1000}, // c17 R5
    {4'd7,  PRE, 2'd3, 1'b0, 4'd8,  4'b0000}, // c18 R7 active time short
    {4'd4,  REF, 2'd0, 1'b0, 4'd0,  4'b0000}, // c19 R4 legal refresh
    {4'd2,  ACT, 2'd2, 1'b0, 4'd0,  4'b0100}, // c20 R2
    {4'd1,  NOP, 2'd0, 1'b0, 4'd0,  4'b0100}, // c21
    {4'd1,  NOP, 2'd0, 1'b0, 4'd0,  4'b0100}, // c22
    {4'd6,  WR,  2'd2, 1'b1, 4'd0,  4'b0100}, // c23 R6 write, auto precharge
    {4'd6,  RD,  2'd2, 1'b0, 4'd6,  4'b0100}, // c24 R6 busy bank
    {4'd6,  NOP, 2'd0, 1'b0, 4'd0,  4'b0100}, // c25 R6
    {4'd6,  NOP, 2'd0, 1'b0, 4'd0,  4'b0000}, // c26 R6 closed after burst
    {4'd6,  NOP, 2'd0, 1'b0, 4'd0,  4'b0000}, // c27
    {4'd6,  NOP, 2'd0, 1'b0, 4'd0,  4'b0000}, // c28
    {4'd6,  ACT, 2'd2, 1'b0, 4'd0,  4'b0100}, // c29 R6 gap exactly TRP
    {4'd4,  REF, 2'd0, 1'b0, 4'd3,  4'b0100}, // c30 R4 refresh, bank open
    {4'd2,  ACT, 2'd1, 1'b0, 4'd0,  4'b0110}  // c31 R2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = DES;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       err_pulse, err_flag;
  logic [3:0] err_code, bank_open;
  int         errs = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(
    .TRCD(3), .TRAS(6), .TRP(3), .TRRD(2), .TWR(2), .TMRD(2), .BL(4),
    .REF_INT(LATE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(pins[3]), .ras_n(pins[2]),
    .cas_n(pins[1]), .we_n(pins[0]), .ba(ba), .a10(a10),
    .err_pulse(err_pulse), .err_code(err_code), .err_flag(err_flag),
    .bank_open(bank_open)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called just after a negedge; applies the command and waits one cycle.
  task automatic step(input logic [3:0] p, input logic [1:0] b, input logic a);
    pins = p; ba = b; a10 = a;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = DES;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL R12 watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: reset state
    chk("R2", "bank_open after reset", int'(bank_open), 0);
    chk("R12", "err_flag after reset", int'(err_flag), 0);
    chk("R12", "err_code after reset", int'(err_code), 0);

    for (int i = 0; i < N_ROWS; i++) begin
      string rq;
      rq = $sformatf("R%0d", int'(TBL[i][18:15]));
      step(TBL[i][14:11], TBL[i][10:9], TBL[i][8]);
      chk(rq, $sformatf("row %0d pulse", i), int'(err_pulse), int'(TBL[i][7:4] != 4'd0));
      if (TBL[i][7:4] != 4'd0)
        chk(rq, $sformatf("row %0d code", i), int'(err_code), int'(TBL[i][7:4]));
      chk(rq, $sformatf("row %0d bank_open", i), int'(bank_open), int'(TBL[i][3:0]));
    end
    // R12: flag sticky, code holds last cause after a clean cycle
    chk("R12", "err_flag held", int'(err_flag), 1);
    chk("R12", "err_code held", int'(err_code), 3);

    // R11 and R1: deselect with row-strobe levels, refresh alarm once
    do_reset();
    for (int i = 0; i <= LATE + 4; i++) begin
      step(DSR, 2'd1, 1'b0);
      chk("R11", $sformatf("late pulse cycle %0d", i), int'(err_pulse), int'(i == LATE));
      chk("R1", $sformatf("deselect bank_open cycle %0d", i), int'(bank_open), 0);
    end
    chk("R11", "late code", int'(err_code), 12);

    // R6: auto-precharge read, burst end placement and tRP from it
    do_reset();
    step(ACT, 2'd1, 1'b0);
    step(NOP, 2'd0, 1'b0);
    step(NOP, 2'd0, 1'b0);
    step(RD,  2'd1, 1'b1);
    chk("R6", "ap read pulse", int'(err_pulse), 0);
    step(NOP, 2'd0, 1'b0);
    step(NOP, 2'd0, 1'b0);
    chk("R6", "open during burst", int'(bank_open), 4'b0010);
    step(NOP, 2'd0, 1'b0);
    chk("R6", "closed after burst", int'(bank_open), 0);
    step(NOP, 2'd0, 1'b0);
    step(ACT, 2'd1, 1'b0);
    chk("R6", "early act pulse", int'(err_pulse), 1);
    chk("R6", "early act code", int'(err_code), 9);

    // R3: single precharge leaves the other bank open
    do_reset();
    step(ACT, 2'd0, 1'b0);
    step(NOP, 2'd0, 1'b0);
    step(ACT, 2'd3, 1'b0);
    for (int i = 0; i < 6; i++) step(NOP, 2'd0, 1'b0);
    step(PRE, 2'd3, 1'b0);
    chk("R3", "single precharge", int'(bank_open), 4'b0001);
    chk("R3", "single precharge pulse", int'(err_pulse), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule